// File: doc/BRIEF.md
# Configurable Parallel Load Register

This block is an N-bit word register. A load-enable input lets it capture the data bus on the active clock edge, and two force inputs drive it to fixed words. Parameters choose the active clock edge, the polarity of the load input and the polarity of the two force inputs. A further parameter chooses whether the force inputs act on the clock edge or at once, with no clock. The word loaded by set, the word loaded by reset and the power-up word are each a parameter. Each is cut to the register width at elaboration.

If set and reset are both active, the request is treated as illegal. Neither input wins and the stored word is left unchanged, even when load is active at the same time. The block is intended for control words and mode registers where the default word and the recovery word are both fixed at build time.

Top module: `plr_top`

## Requirements
- R1: Without any clock edge, the output shows INIT_VAL cut to its low W bits (15 for an initial value of 15).
- R2: The output updates only on the edge chosen by RISE_EDGE: rising when it is 1, falling when it is 0. The other edge never changes the output.
- R3: With LOAD_HIGH = 1, load = 1 is active. With LOAD_HIGH = 0, load = 0 is active. When load is active and set and reset are both inactive, the active edge copies d_i to q_o.
- R4: When load, set and reset are all inactive, an active edge leaves q_o unchanged.
- R5: With SR_HIGH = 1, set and reset are active at level 1. With SR_HIGH = 0, they are active at level 0.
- R6: With ASYNC_SR = 0, an active set alone puts SET_VAL on q_o at the next active edge and an active reset alone puts RST_VAL there. Before that edge q_o does not change, and the force takes priority over load.
- R7: With ASYNC_SR = 1, an active set alone puts SET_VAL on q_o at once, with no clock. An active reset alone puts RST_VAL there at once. The forced word stays through active edges, whatever the level of load.
- R8: When set and reset are both active, q_o keeps its last value in both modes, even when load is active on an active edge.
- R9: With ASYNC_SR = 1, after the force is released q_o keeps the forced word. Loading resumes at the next active edge that finds set and reset both inactive.
- R10: SET_VAL and RST_VAL are cut to their low W bits. For W = 4, 'h3B gives 11 and 'h21 gives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the active edge is chosen by RISE_EDGE |
| load_i | input | 1 | Load enable; polarity chosen by LOAD_HIGH |
| set_i | input | 1 | Force to SET_VAL; polarity chosen by SR_HIGH |
| rst_i | input | 1 | Force to RST_VAL; polarity chosen by SR_HIGH |
| d_i | input | W | Data word captured on a load |
| q_o | output | W | Stored word |

## Verification
A load, a hold and a synchronous force are due in the first active-edge sample after the inputs are driven. The bench therefore drives each instance just after its inactive edge and reads the output 1 ns after the next active edge. An asynchronous force is due at once, so it is read 0.5 ns after the pin changes, with no clock edge in between. Reads taken after an inactive edge confirm that edge does nothing. Reads taken before an active edge confirm that a synchronous force waits for the edge.

// File: rtl/plr_pkg.sv
`timescale 1ns/100ps
package plr_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD, ACT_LOAD, ACT_SET, ACT_RST, ACT_CLASH
  } plr_act_e;

  // pin level -> active flag, given the active polarity
  function automatic logic lvl_on(input logic pin, input bit act_high);
    return act_high ? pin : ~pin;
  endfunction

  // priority of requests: a clash beats everything, force beats load
  function automatic plr_act_e decide(input logic ld, input logic st, input logic rs);
    if (st && rs)  return ACT_CLASH;
    else if (st)   return ACT_SET;
    else if (rs)   return ACT_RST;
    else if (ld)   return ACT_LOAD;
    else           return ACT_HOLD;
  endfunction
endpackage

// File: rtl/plr_pin_norm.sv
`timescale 1ns/100ps
module plr_pin_norm
  import plr_pkg::*;
#(
  parameter bit ACT_HIGH = 1'b1
) (
  input  logic pin_i,
  output logic on_o
);
  assign on_o = lvl_on(pin_i, ACT_HIGH);
endmodule

// File: rtl/plr_decide.sv
`timescale 1ns/100ps
module plr_decide
  import plr_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] SET_W = '0,
  parameter logic [W-1:0] RST_W = '0
) (
  input  logic         ld_on,
  input  logic         set_on,
  input  logic         rst_on,
  input  logic [W-1:0] d,
  output plr_act_e     act,
  output logic         upd,
  output logic [W-1:0] nxt
);
  always_comb begin
    act = decide(ld_on, set_on, rst_on);
    upd = 1'b1;
    nxt = d;
    unique case (act)
      ACT_LOAD: nxt = d;
      ACT_SET:  nxt = SET_W;
      ACT_RST:  nxt = RST_W;
      default:  upd = 1'b0;
    endcase
  end
endmodule

// File: rtl/plr_store.sv
`timescale 1ns/100ps
module plr_store #(
  parameter int unsigned W = 8,
  parameter bit RISE = 1'b1,
  parameter bit ASYNC = 1'b0,
  parameter logic [W-1:0] SET_W = '0,
  parameter logic [W-1:0] RST_W = '0,
  parameter logic [W-1:0] INIT_W = '0
) (
  input  logic         clk,
  input  logic         frc_set,   // exclusive async set request (0 in sync mode)
  input  logic         frc_rst,   // exclusive async reset request (0 in sync mode)
  input  logic         upd,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r = INIT_W;
  logic smp_clk;
  assign smp_clk = RISE ? clk : ~clk;

  if (RISE && ASYNC) begin : g_rise_async
    always_ff @(posedge clk or posedge frc_set or posedge frc_rst)
      if (frc_set)      q_r <= SET_W;
      else if (frc_rst) q_r <= RST_W;
      else if (upd)     q_r <= nxt;
  end else if (!RISE && ASYNC) begin : g_fall_async
    always_ff @(negedge clk or posedge frc_set or posedge frc_rst)
      if (frc_set)      q_r <= SET_W;
      else if (frc_rst) q_r <= RST_W;
      else if (upd)     q_r <= nxt;
  end else if (RISE) begin : g_rise_sync
    always_ff @(posedge clk)
      if (upd) q_r <= nxt;
  end else begin : g_fall_sync
    always_ff @(negedge clk)
      if (upd) q_r <= nxt;
  end

  assign q = q_r;

  AST_UPD_TAKES: assert property (@(posedge smp_clk) disable iff (frc_set || frc_rst)
    upd |=> q_r == $past(nxt)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge smp_clk) disable iff (frc_set || frc_rst)
    !upd |=> $stable(q_r)); // R4
  AST_ASYNC_SET_WORD: assert property (@(posedge smp_clk)
    frc_set |-> q_r == SET_W); // R7
  AST_ASYNC_RST_WORD: assert property (@(posedge smp_clk)
    frc_rst |-> q_r == RST_W); // R7
endmodule

// File: rtl/plr_top.sv
`timescale 1ns/100ps
module plr_top
  import plr_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter bit RISE_EDGE = 1'b1,
  parameter bit LOAD_HIGH = 1'b1,
  parameter bit SR_HIGH = 1'b1,
  parameter bit ASYNC_SR = 1'b0,
  parameter longint unsigned SET_VAL = 64'hFF,
  parameter longint unsigned RST_VAL = 64'h0,
  parameter longint unsigned INIT_VAL = 64'h0
) (
  input  logic         clk,
  input  logic         load_i,
  input  logic         set_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] SET_W  = W'(SET_VAL);  // R10
  localparam logic [W-1:0] RST_W  = W'(RST_VAL);
  localparam logic [W-1:0] INIT_W = W'(INIT_VAL); // R1

  logic ld_on, set_on, rst_on;
  logic frc_set, frc_rst;   // named force events for the checks
  logic upd;
  logic [W-1:0] nxt;
  plr_act_e act;
  logic smp_clk;

  plr_pin_norm #(.ACT_HIGH(LOAD_HIGH)) u_ld  (.pin_i(load_i), .on_o(ld_on));
  plr_pin_norm #(.ACT_HIGH(SR_HIGH))   u_set (.pin_i(set_i),  .on_o(set_on)); // R5
  plr_pin_norm #(.ACT_HIGH(SR_HIGH))   u_rst (.pin_i(rst_i),  .on_o(rst_on));

  // async force only when exactly one of set/reset is active; clash holds
  assign frc_set = ASYNC_SR & set_on & ~rst_on;
  assign frc_rst = ASYNC_SR & rst_on & ~set_on;
  assign smp_clk = RISE_EDGE ? clk : ~clk;

  plr_decide #(.W(W), .SET_W(SET_W), .RST_W(RST_W)) u_dec (
    .ld_on(ld_on), .set_on(set_on), .rst_on(rst_on), .d(d_i),
    .act(act), .upd(upd), .nxt(nxt)
  );

  plr_store #(.W(W), .RISE(RISE_EDGE), .ASYNC(ASYNC_SR),
              .SET_W(SET_W), .RST_W(RST_W), .INIT_W(INIT_W)) u_sto (
    .clk(clk), .frc_set(frc_set), .frc_rst(frc_rst),
    .upd(upd), .nxt(nxt), .q(q_o)
  );

  AST_CLASH_HOLDS: assert property (@(posedge smp_clk) disable iff (frc_set || frc_rst)
    (act == ACT_CLASH) |=> $stable(q_o)); // R8

  if (!ASYNC_SR) begin : g_sync_chk
    AST_SYNC_SET: assert property (@(posedge smp_clk)
      (set_on && !rst_on) |=> q_o == SET_W); // R6
    AST_SYNC_RST: assert property (@(posedge smp_clk)
      (rst_on && !set_on) |=> q_o == RST_W); // R6
  end
endmodule

// File: tb/plr_top_test.sv
`timescale 1ns/100ps
module plr_top_test;
  typedef struct packed {
    logic ld; logic st; logic rs; logic [7:0] d; logic [7:0] q;
  } vec_t;

  // instance A: 8 bit, rising, active-high pins, sync force, SET=C3 RST=3C INIT=15
  localparam vec_t TAB_A [10] = '{
    '{1'b1,1'b0,1'b0,8'd4,  8'd4},    // R3 load
    '{1'b0,1'b0,1'b0,8'd9,  8'd4},    // R4 hold
    '{1'b1,1'b0,1'b0,8'd8,  8'd8},    // R3
    '{1'b0,1'b0,1'b0,8'd8,  8'd8},    // R4
    '{1'b1,1'b1,1'b0,8'd77, 8'hC3},   // R6 set over load
    '{1'b1,1'b0,1'b1,8'd77, 8'h3C},   // R6 reset over load
    '{1'b1,1'b1,1'b1,8'd99, 8'h3C},   // R8 clash with load
    '{1'b0,1'b1,1'b1,8'd0,  8'h3C},   // R8
    '{1'b1,1'b0,1'b0,8'd5,  8'd5},    // R3
    '{1'b0,1'b1,1'b0,8'd0,  8'hC3}    // R6
  };
  // instance B: 4 bit, falling, active-low pins (raw levels), async, SET=11 RST=1 INIT=15
  localparam vec_t TAB_B [8] = '{
    '{1'b0,1'b1,1'b1,8'd4, 8'd4},     // R3 R5 load on low
    '{1'b1,1'b1,1'b1,8'd9, 8'd4},     // R4
    '{1'b0,1'b1,1'b1,8'd8, 8'd8},     // R3
    '{1'b0,1'b0,1'b1,8'd3, 8'd11},    // R7 R10 set over load
    '{1'b0,1'b1,1'b0,8'd3, 8'd1},     // R7 R10 reset
    '{1'b0,1'b0,1'b0,8'd3, 8'd1},     // R8 clash with load
    '{1'b0,1'b1,1'b1,8'd6, 8'd6},     // R9 resume
    '{1'b1,1'b1,1'b1,8'd2, 8'd6}      // R4
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic ld_a = 1'b0, st_a = 1'b0, rs_a = 1'b0;
  logic [7:0] d_a = '0, q_a;
  logic ld_b = 1'b1, st_b = 1'b1, rs_b = 1'b1;
  logic [3:0] d_b = '0, q_b;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  plr_top #(.W(8), .RISE_EDGE(1'b1), .LOAD_HIGH(1'b1), .SR_HIGH(1'b1), .ASYNC_SR(1'b0),
            .SET_VAL(64'hC3), .RST_VAL(64'h3C), .INIT_VAL(64'd15)) uut (
    .clk(clk), .load_i(ld_a), .set_i(st_a), .rst_i(rs_a), .d_i(d_a), .q_o(q_a));

  plr_top #(.W(4), .RISE_EDGE(1'b0), .LOAD_HIGH(1'b0), .SR_HIGH(1'b0), .ASYNC_SR(1'b1),
            .SET_VAL(64'h3B), .RST_VAL(64'h21), .INIT_VAL(64'h7F)) uut_b (
    .clk(clk), .load_i(ld_b), .set_i(st_b), .rst_i(rs_b), .d_i(d_b), .q_o(q_b));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #1;
    chk("R1 power-on A", q_a, 8'd15);
    chk("R1 R10 power-on B", {4'h0, q_b}, 8'd15);

    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #0.5;
      ld_a = TAB_A[i].ld; st_a = TAB_A[i].st; rs_a = TAB_A[i].rs; d_a = TAB_A[i].d;
      @(posedge clk); #1;
      chk($sformatf("table A row %0d (R3 R4 R6 R8)", i), q_a, TAB_A[i].q);
    end
    // R6: sync reset waits for the edge
    @(negedge clk); #0.5; ld_a = 1'b0; st_a = 1'b0; rs_a = 1'b1;
    #1; chk("R6 no change before edge", q_a, 8'hC3);
    @(posedge clk); #1; chk("R6 reset at edge", q_a, 8'h3C);
    // R2: falling edge ignored on the rising-edge instance
    @(negedge clk); #0.5; rs_a = 1'b0; ld_a = 1'b1; d_a = 8'h42;
    @(posedge clk); #1; chk("R2 rising capture", q_a, 8'h42);
    #0.5; d_a = 8'h11;
    @(negedge clk); #1; chk("R2 falling edge ignored", q_a, 8'h42);
    @(posedge clk); #1; chk("R2 next rising capture", q_a, 8'h11);
    ld_a = 1'b0;

    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #0.5;
      ld_b = TAB_B[i].ld; st_b = TAB_B[i].st; rs_b = TAB_B[i].rs; d_b = TAB_B[i].d[3:0];
      @(negedge clk); #1;
      chk($sformatf("table B row %0d (R3 R5 R7 R8 R9)", i), {4'h0, q_b}, TAB_B[i].q);
    end
    // R2: rising edge ignored on the falling-edge instance
    @(negedge clk); #0.5; ld_b = 1'b0; d_b = 4'd9;
    @(posedge clk); #1; chk("R2 rising edge ignored", {4'h0, q_b}, 8'd6);
    @(negedge clk); #1; chk("R2 falling capture", {4'h0, q_b}, 8'd9);
    // R7: immediate set, persists over an edge with load active
    @(posedge clk); #0.5; st_b = 1'b0; d_b = 4'd5;
    #0.5; chk("R7 immediate set", {4'h0, q_b}, 8'd11);
    @(negedge clk); #1; chk("R7 set holds over load edge", {4'h0, q_b}, 8'd11);
    // R9: release keeps word until next edge
    @(posedge clk); #0.5; st_b = 1'b1;
    #0.5; chk("R9 word kept after release", {4'h0, q_b}, 8'd11);
    @(negedge clk); #1; chk("R9 load resumes", {4'h0, q_b}, 8'd5);
    #0.5; ld_b = 1'b1; rs_b = 1'b0;
    #0.5; chk("R7 immediate reset", {4'h0, q_b}, 8'd1);
    st_b = 1'b0;
    #0.5; chk("R8 async clash holds", {4'h0, q_b}, 8'd1);
    rs_b = 1'b1;
    #0.5; chk("R7 set takes over on reset release", {4'h0, q_b}, 8'd11);
    st_b = 1'b1;
    #0.5; chk("R9 hold after full release", {4'h0, q_b}, 8'd11);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule